// File: doc/BRIEF.md
# Prefix-Sum Thread ID Allocator

This unit hands out thread IDs to a set of thread control units during an explicit spawn. A spawn is opened with an inclusive low bound and an exclusive high bound. From then on, every requester asks for its next ID by raising its request bit. All requests raised in the same cycle are served together. A parallel prefix sum over the request mask gives each requester its rank among that cycle's requesters. The rank is added to a shared counter, so the IDs handed out in one cycle are unique and consecutive.

An ID at or past the high bound comes back flagged invalid. That flag tells the requester to stop asking. Requesters report each finished thread on a one-cycle completion line. Once the range is exhausted and every valid ID has been reported finished, the unit signals join and returns to idle. The number of threads in a spawn may be far larger than the number of requesters.

Top module: `tid_alloc`

## Requirements
- R1: While reset is held and right after it, `busy`, `join_done`, `grant_vld` and `id_ok` are all low.
- R2: A `spawn_go` seen while idle loads the counter with `spawn_lo` and the bound with `spawn_hi`, and raises `busy` from the next cycle. A `spawn_go` seen while busy changes neither the counter nor the bound.
- R3: While busy, `grant_vld[i]` in a cycle equals `req[i]` of the previous cycle. A request made while idle gets no grant.
- R4: The ID granted to requester i equals the counter plus the number of lower-numbered requesters in the same cycle, taken modulo 2^IDW. This is an exclusive prefix sum of the request mask, so a full mask gets base .. base+NREQ-1 with lane 0 lowest. Each ID is carried on `grant_id[i*IDW +: IDW]`.
- R5: In each busy cycle where the counter is below the bound, the counter advances by the number of requests. Once the counter reaches the bound it holds.
- R6: `id_ok[i]` is high together with `grant_vld[i]` exactly when the granted ID, taken without wrap, is below the high bound.
- R7: Each valid grant adds one outstanding thread at issue, and each set bit of `done_pulse` retires one. Issue and retirement in the same cycle both count.
- R8: When busy, with the counter at or past the bound and no thread outstanding, `join_done` is high for exactly one cycle on the next cycle and `busy` falls at the same edge. A spawn whose low bound is not below its high bound therefore joins one cycle after it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawn_go | input | 1 | Open a spawn (only taken when idle) |
| spawn_lo | input | IDW | First thread ID of the spawn |
| spawn_hi | input | IDW | Exclusive upper bound of the spawn |
| req | input | NREQ | One ID request per requester |
| done_pulse | input | NREQ | Thread-finished report, one bit per requester |
| grant_vld | output | NREQ | Grant returned for last cycle's request |
| id_ok | output | NREQ | Granted ID lies below the bound |
| grant_id | output | NREQ*IDW | Granted IDs, lane i at bits i*IDW +: IDW |
| busy | output | 1 | A spawn is in progress |
| join_done | output | 1 | One-cycle pulse when the spawn completes |

## Verification
Two things can happen in the same cycle: new valid IDs are issued and earlier threads report completion. The bench provokes this by driving random completion bits, bounded by the model's outstanding count, alongside random request masks. A join that is too early or too late shows up as a mismatch in `join_done` and `busy` against the behavioural model. A second collision is a `spawn_go` that arrives during a running spawn, including the cycle the join condition is reached. It is judged by the IDs granted afterwards, which must still follow the first spawn's counter and bound.

// File: rtl/tid_pkg.sv
package tid_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} tid_state_e;
endpackage

// File: rtl/tid_prefix.sv
// Exclusive prefix count of a request mask, log2(N)-level parallel scan.
module tid_prefix #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    mask,
  output logic [N*CW-1:0] rank,
  output logic [CW-1:0]   total
);
  localparam int LV = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] stage [LV+1][N];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign stage[0][i] = CW'(mask[i]);
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= (1 << l)) begin : g_add
        assign stage[l+1][i] = stage[l][i] + stage[l][i-(1<<l)];
      end else begin : g_pass
        assign stage[l+1][i] = stage[l][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign rank[i*CW +: CW] = stage[LV][i] - CW'(mask[i]);
  end

  assign total = stage[LV][N-1];
endmodule

// File: rtl/tid_count.sv
// Population count of a vector.
module tid_count #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/tid_alloc.sv
module tid_alloc
  import tid_pkg::*;
#(
  parameter int NREQ = 8,
  parameter int IDW  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spawn_go,
  input  logic [IDW-1:0]      spawn_lo,
  input  logic [IDW-1:0]      spawn_hi,
  input  logic [NREQ-1:0]     req,
  input  logic [NREQ-1:0]     done_pulse,
  output logic [NREQ-1:0]     grant_vld,
  output logic [NREQ-1:0]     id_ok,
  output logic [NREQ*IDW-1:0] grant_id,
  output logic                busy,
  output logic                join_done
);
  localparam int CW = $clog2(NREQ + 1);
  localparam int OW = IDW + 1;

  tid_state_e           st_q, st_d;
  logic [OW-1:0]        ctr_q, ctr_d, hi_q, hi_d, outst_q, outst_d;
  logic [NREQ-1:0]      gv_q, ok_q, ok_w, req_eff;
  logic [NREQ*IDW-1:0]  gid_q, id_flat;
  logic                 join_q, join_d, gid_en, exhausted;
  logic [NREQ*CW-1:0]   rank;
  logic [CW-1:0]        total, nvalid, ndone;
  logic [OW-1:0]        id_w [NREQ];

  assign req_eff   = (st_q == ST_RUN) ? req : '0;
  assign exhausted = (ctr_q >= hi_q);

  tid_prefix #(.N(NREQ), .CW(CW)) u_scan (
    .mask(req_eff), .rank(rank), .total(total));

  for (genvar i = 0; i < NREQ; i++) begin : g_lane
    assign id_w[i] = ctr_q + OW'(rank[i*CW +: CW]);
    assign ok_w[i] = req_eff[i] && (id_w[i] < hi_q);
    assign id_flat[i*IDW +: IDW] = id_w[i][IDW-1:0];
  end

  tid_count #(.N(NREQ), .CW(CW)) u_nvalid (.bits(ok_w), .count(nvalid));
  tid_count #(.N(NREQ), .CW(CW)) u_ndone  (.bits(done_pulse), .count(ndone));

  assign gid_en = |req_eff;

  always_comb begin
    st_d    = st_q;
    ctr_d   = ctr_q;
    hi_d    = hi_q;
    outst_d = outst_q;
    join_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (spawn_go) begin
          st_d    = ST_RUN;
          ctr_d   = {1'b0, spawn_lo};
          hi_d    = {1'b0, spawn_hi};
          outst_d = '0;
        end
      end
      ST_RUN: begin
        if (exhausted && (outst_q == '0)) begin
          st_d   = ST_IDLE;
          join_d = 1'b1;
        end else begin
          if (!exhausted) ctr_d = ctr_q + OW'(total);
          outst_d = outst_q + OW'(nvalid) - OW'(ndone);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ctr_q   <= '0;
      hi_q    <= '0;
      outst_q <= '0;
      join_q  <= 1'b0;
      gv_q    <= '0;
      ok_q    <= '0;
    end else begin
      st_q    <= st_d;
      ctr_q   <= ctr_d;
      hi_q    <= hi_d;
      outst_q <= outst_d;
      join_q  <= join_d;
      gv_q    <= req_eff;
      ok_q    <= ok_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gid_q <= '0;
    else if (gid_en) gid_q <= id_flat;
  end

  assign grant_vld = gv_q;
  assign id_ok     = ok_q;
  assign grant_id  = gid_q;
  assign busy      = (st_q == ST_RUN);
  assign join_done = join_q;
endmodule

// File: rtl/tid_alloc_chk.sv
module tid_alloc_chk #(
  parameter int NREQ = 8,
  parameter int IDW  = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            spawn_go,
  input logic [NREQ-1:0] req,
  input logic [NREQ-1:0] grant_vld,
  input logic [NREQ-1:0] id_ok,
  input logic            busy,
  input logic            join_done
);
  p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld & ~$past(req)) == '0);

  p_ok_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_ok & ~grant_vld) == '0);

  p_join_leaves_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |-> !busy);

  p_join_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |=> !join_done);

  p_busy_until_join_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || join_done));

  p_start_needs_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(spawn_go));
endmodule

bind tid_alloc tid_alloc_chk #(.NREQ(NREQ), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spawn_go(spawn_go), .req(req),
  .grant_vld(grant_vld), .id_ok(id_ok), .busy(busy), .join_done(join_done));

// File: tb/tid_alloc_test.sv
module tid_alloc_test;
  localparam int NREQ = 8;
  localparam int IDW  = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n;
  logic                spawn_go;
  logic [IDW-1:0]      spawn_lo, spawn_hi;
  logic [NREQ-1:0]     req, done_pulse;
  logic [NREQ-1:0]     grant_vld, id_ok;
  logic [NREQ*IDW-1:0] grant_id;
  logic                busy, join_done;

  tid_alloc #(.NREQ(NREQ), .IDW(IDW)) uut (
    .clk(clk), .rst_n(rst_n), .spawn_go(spawn_go), .spawn_lo(spawn_lo),
    .spawn_hi(spawn_hi), .req(req), .done_pulse(done_pulse),
    .grant_vld(grant_vld), .id_ok(id_ok), .grant_id(grant_id),
    .busy(busy), .join_done(join_done));

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  // behavioural reference state
  bit              m_act;
  int              m_ctr, m_hi, m_outst;
  logic [NREQ-1:0] e_gv, e_ok;
  int              e_id [NREQ];
  bit              e_join;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_edge();
    int r = 0, nv = 0, nd;
    nd = $countones(done_pulse);
    e_gv = '0; e_ok = '0; e_join = 1'b0;
    if (m_act) begin
      for (int i = 0; i < NREQ; i++) begin
        if (req[i]) begin
          e_gv[i] = 1'b1;
          e_id[i] = (m_ctr + r) % (1 << IDW);
          if (m_ctr + r < m_hi) begin e_ok[i] = 1'b1; nv++; end
          r++;
        end
      end
      if (m_ctr >= m_hi && m_outst == 0) begin
        e_join = 1'b1; m_act = 1'b0;
      end else begin
        if (m_ctr < m_hi) m_ctr += r;
        m_outst += nv - nd;
      end
    end else if (spawn_go) begin
      m_act = 1'b1; m_ctr = int'(spawn_lo); m_hi = int'(spawn_hi); m_outst = 0;
    end
  endtask

  task automatic compare();
    chk("R2 busy", int'(busy), int'(m_act));
    chk("R8 join_done", int'(join_done), int'(e_join));
    chk("R3 grant_vld", int'(grant_vld), int'(e_gv));
    chk("R6 id_ok", int'(id_ok), int'(e_ok));
    for (int i = 0; i < NREQ; i++)
      if (e_gv[i]) chk("R4 grant_id", int'(grant_id[i*IDW +: IDW]), e_id[i]);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic drive(bit go, int lo, int hi, logic [NREQ-1:0] rq, logic [NREQ-1:0] dn);
    spawn_go = go; spawn_lo = IDW'(lo); spawn_hi = IDW'(hi); req = rq; done_pulse = dn;
    step();
  endtask

  function automatic logic [NREQ-1:0] pick_done();
    logic [NREQ-1:0] d = '0;
    int want = $urandom_range(0, 3);
    if (want > m_outst) want = m_outst;
    for (int k = 0; k < want; k++) d[k] = 1'b1;
    return (d << ($urandom_range(0, NREQ - want))) ;
  endfunction

  // run a spawn to its join with random traffic; intrude with spawn_go
  task automatic run_spawn(int lo, int hi);
    drive(1'b1, lo, hi, '0, '0);
    for (int n = 0; n < 4000 && m_act; n++) begin
      logic [NREQ-1:0] rq = NREQ'($urandom);
      bit intr = ($urandom_range(0, 9) == 0);  // R2: ignored while busy
      drive(intr, 0, 4000, rq, pick_done());
    end
  endtask

  initial begin
    rst_n = 1'b0; spawn_go = 1'b0; spawn_lo = '0; spawn_hi = '0;
    req = '0; done_pulse = '0;
    m_act = 1'b0; m_ctr = 0; m_hi = 0; m_outst = 0; e_gv = '0; e_ok = '0; e_join = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 join_done", int'(join_done), 0);
    chk("R1 grant_vld", int'(grant_vld), 0);
    chk("R1 id_ok", int'(id_ok), 0);
    rst_n = 1'b1;
    // R3 requests while idle yield nothing
    drive(1'b0, 0, 0, '1, '0);
    drive(1'b0, 0, 0, '0, '0);
    chk("R3 idle request", int'(grant_vld), 0);
    // R2/R4 full mask from base 10
    drive(1'b1, 10, 30, '0, '0);
    drive(1'b0, 0, 0, '1, '0);
    chk("R4 lane0 base", int'(grant_id[0 +: IDW]), 10);
    chk("R4 lane7 top", int'(grant_id[7*IDW +: IDW]), 17);
    // R2 spawn_go while busy with other bounds, R4 sparse mask
    drive(1'b1, 500, 900, 8'b1010_0100, 8'b0000_0011);
    chk("R4 sparse lane2", int'(grant_id[2*IDW +: IDW]), 18);
    chk("R4 sparse lane7", int'(grant_id[7*IDW +: IDW]), 20);
    // R5/R6 cross the bound: counter 21, bound 30, full mask
    drive(1'b0, 0, 0, '1, 8'b0000_1100);
    chk("R6 bound split", int'(id_ok), 8'b1111_1111);
    drive(1'b0, 0, 0, '1, '0);
    chk("R6 past bound", int'(id_ok), 8'b0000_0001);
    drive(1'b0, 0, 0, '1, '0);
    chk("R5 counter holds", int'(id_ok), 0);
    // R7 retire remaining with overlap, until join (R8)
    for (int n = 0; n < 100 && m_act; n++) drive(1'b0, 0, 0, '0, pick_done());
    chk("R8 joined", int'(busy), 0);
    // R8 empty spawn joins one cycle after start
    drive(1'b1, 40, 40, '0, '0);
    drive(1'b0, 0, 0, '0, '0);
    chk("R8 empty join", int'(join_done), 1);
    // R4 wrap near the top of the ID space
    drive(1'b1, 4090, 4095, '0, '0);
    drive(1'b0, 0, 0, '1, '0);
    chk("R4 wrap lane7", int'(grant_id[7*IDW +: IDW]), 1);
    chk("R6 wrap valid", int'(id_ok), 8'b0001_1111);
    for (int n = 0; n < 100 && m_act; n++) drive(1'b0, 0, 0, '0, pick_done());
    // R7 random long spawns
    run_spawn(0, 700);
    run_spawn(123, 130);
    run_spawn(1000, 3000);
    drive(1'b0, 0, 0, '0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule